// File: doc/BRIEF.md
# Per-Byte Parity Monitor for a 36-bit Bus

The block watches a 36-bit data bus and raises an active-low error flag whenever the word on the bus carries bad parity. The word is split into four 9-bit lanes. Each lane's parity is judged on its own, and the lane results are merged into the single flag. The flag is a pure function of the bus and the stored settings. It therefore reports on any word seen at the bus, wherever that word came from.

Two settings live in a small control register that is written through a simple write port. One setting chooses whether a lane must hold an odd or an even number of ones. The other decides whether the width selection input narrows the set of lanes that are checked. When narrowing is on, the width select picks the full word, the lower half or the lowest lane. Lanes outside that field are masked. When narrowing is off, all four lanes are checked whatever the width select says.

Top module: `byte_parity_monitor`

## Requirements
- R1: The bus is checked as four separate lanes: bits 8:0 (lane 0), 17:9 (lane 1), 26:18 (lane 2) and 35:27 (lane 3). Each lane is judged only on its own nine bits.
- R2: `perr_n` is 0 when at least one checked lane has a parity error, and 1 when no checked lane has one.
- R3: After reset the block is in odd mode with narrowing off. A lane of nine bits with an even number of ones is then an error, and all four lanes are checked.
- R4: Control bit 0 selects the mode. A value of 0 means odd mode, where a lane must hold an odd count of ones. A value of 1 means even mode, where a lane must hold an even count of ones. A write takes effect from the rising clock edge on which `cfg_we` is 1.
- R5: With control bit 9 set, `width_sel` 00 checks lanes 0 to 3, `width_sel` 01 checks lanes 0 and 1, and `width_sel` 10 or 11 checks lane 0 only.
- R6: With control bit 9 clear, all four lanes are checked for every value of `width_sel`.
- R7: A lane outside the selected field never pulls `perr_n` low, whatever its contents.
- R8: `perr_n` follows the bus, `width_sel` and the stored settings within the same cycle, with no clock edge in the path.
- R9: When `cfg_we` is 0, the stored settings keep their values. All `cfg_wdata` bits other than 0 and 9 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the control register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control register write data (bit 0 mode, bit 9 narrowing) |
| bus_data | input | 36 | Monitored data word |
| width_sel | input | 2 | Word width selection |
| perr_n | output | 1 | Active-low parity error flag |

## Verification
The flag has no register in its path, so it is due in the same cycle as the bus and width-select values that produce it. The bench drives every vector at the falling edge and compares the flag 1 ns later, well before the next rising edge. A control write becomes visible only after the rising edge that captures it. The bench model therefore updates its copy of the settings at that edge, and the next vector is the first one judged under the new mode. Vectors that arrive with the write strobe low, or with stray control bits set, are judged under the old settings. This exposes any write that leaks through.

// File: rtl/byte_parity_monitor.sv
module byte_parity_monitor #(
  parameter int LANE_W     = 9,
  parameter int LANES      = 4,
  parameter int CFG_W      = 16,
  parameter int MODE_BIT   = 0,
  parameter int NARROW_BIT = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [CFG_W-1:0]          cfg_wdata,
  input  logic [LANE_W*LANES-1:0]   bus_data,
  input  logic [1:0]                width_sel,
  output logic                      perr_n
);

  localparam int HALF = LANES / 2;

  logic             even_q;
  logic             narrow_q;
  logic [LANES-1:0] lane_err;
  logic [LANES-1:0] lane_en;
  int               active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      even_q   <= 1'b0;
      narrow_q <= 1'b0;
    end else if (cfg_we) begin
      even_q   <= cfg_wdata[MODE_BIT];
      narrow_q <= cfg_wdata[NARROW_BIT];
    end
  end

  always_comb begin
    if (!narrow_q || width_sel == 2'b00) active = LANES;
    else if (width_sel == 2'b01)         active = HALF;
    else                                 active = 1;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_err[i] = ((^bus_data[i*LANE_W +: LANE_W]) == even_q);
    assign lane_en[i]  = (i < active);
  end

  assign perr_n = ~|(lane_err & lane_en);

  // R2: a low flag always traces back to some lane in error
  a_r2_flag_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |-> |lane_err);

  // R6: without narrowing, any lane error shows on the flag
  a_r6_full_check: assert property (@(posedge clk) disable iff (!rst_n)
    (!narrow_q && |lane_err) |-> !perr_n);

  // R7: narrowed to a single lane, only lane 0 can drive the flag low
  a_r7_single_lane_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow_q && width_sel[1] && !perr_n) |-> lane_err[0]);

  // R4: a write loads the mode bit at the next edge
  a_r4_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> even_q == $past(cfg_wdata[MODE_BIT]));

  // R9: without a write strobe the settings hold
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(even_q) && $stable(narrow_q)));

endmodule

// File: tb/test_byte_parity_monitor.sv
module test_byte_parity_monitor;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [35:0] bus_data = '0;
  logic [1:0]  width_sel = '0;
  logic        perr_n;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;
  bit m_even  = 1'b0;
  bit m_narrow = 1'b0;

  always #2 clk = ~clk;

  byte_parity_monitor i_byte_parity_monitor (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .bus_data(bus_data), .width_sel(width_sel), .perr_n(perr_n)
  );

  function automatic logic model_flag(logic [35:0] w, logic [1:0] ws, bit ev, bit nar);
    int n;
    logic bad = 1'b0;
    n = (!nar || ws == 2'b00) ? 4 : (ws == 2'b01 ? 2 : 1);
    for (int i = 0; i < n; i++)
      if ((^w[i*9 +: 9]) == ev) bad = 1'b1;
    return !bad;
  endfunction

  function automatic logic [35:0] good_word(bit ev);
    logic [35:0] w;
    w = {$urandom, $urandom};
    for (int i = 0; i < 4; i++)
      w[i*9+8] = (^w[i*9 +: 8]) ^ ~ev;
    return w;
  endfunction

  task automatic apply(string tag, logic [35:0] w, logic [1:0] ws,
                       logic we = 1'b0, logic [15:0] wd = '0);
    logic exp;
    @(negedge clk);
    bus_data = w; width_sel = ws; cfg_we = we; cfg_wdata = wd;
    #1;
    exp = model_flag(w, ws, m_even, m_narrow);
    vectors++;
    if (perr_n !== exp) begin
      misses++;
      $display("FAIL %s: perr_n=%b expected %b (bus=%h ws=%b)", tag, perr_n, exp, w, ws);
    end
    @(posedge clk);
    if (we) begin m_even = wd[0]; m_narrow = wd[9]; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    misses++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R3: reset state, all-zero lanes hold an even count
    apply("R3 zero word odd mode", 36'h0, 2'b11);
    apply("R3 one bit per lane", {9'h1, 9'h1, 9'h1, 9'h1}, 2'b00);
    // R1: a single bad lane at each position
    for (int i = 0; i < 4; i++)
      apply("R1 single bad lane", {9'h1, 9'h1, 9'h1, 9'h1} & ~(36'h1 << (i*9)), 2'b00);
    // R1: two flips inside one lane cancel
    apply("R1 double flip in lane", {9'h1, 9'h1, 9'h7, 9'h1}, 2'b00);
    // R6: narrowing off ignores width_sel
    apply("R6 upper lane bad ws=10", {9'h0, 9'h1, 9'h1, 9'h1}, 2'b10);
    apply("R6 upper lane bad ws=01", {9'h1, 9'h0, 9'h1, 9'h1}, 2'b01);
    // R9: stray bits with strobe low, then write with other bits set
    apply("R9 strobe low", {9'h1, 9'h1, 9'h1, 9'h1}, 2'b00, 1'b0, 16'hffff);
    apply("R9 still odd", 36'h0, 2'b00);
    apply("R9 stray bits write", 36'h0, 2'b00, 1'b1, 16'hfdfe);
    apply("R9 stray bits ignored", 36'h0, 2'b10);
    // R4: switch to even mode
    apply("R4 write even", 36'h0, 2'b00, 1'b1, 16'h0001);
    apply("R4 even zero word ok", 36'h0, 2'b00);
    apply("R4 even odd lane bad", {9'h0, 9'h0, 9'h0, 9'h100}, 2'b00);
    // R5 / R7: narrowing on, even mode
    apply("R5 write narrow", 36'h0, 2'b00, 1'b1, 16'h0201);
    apply("R7 half masks upper", {9'h1, 9'h1, 9'h0, 9'h0}, 2'b01);
    apply("R5 half sees lane1", {9'h0, 9'h0, 9'h1, 9'h0}, 2'b01);
    apply("R7 byte masks lane1", {9'h1, 9'h1, 9'h1, 9'h0}, 2'b10);
    apply("R5 byte sees lane0", {9'h0, 9'h0, 9'h0, 9'h1}, 2'b11);
    apply("R5 full sees lane3", {9'h1, 9'h0, 9'h0, 9'h0}, 2'b00);

    // R8 / R2: random mix, flag judged in the same cycle
    for (int n = 0; n < 3000; n++) begin
      logic [35:0] w;
      logic we;
      logic [15:0] wd;
      w = good_word(m_even);
      if ($urandom_range(0, 1)) w[$urandom_range(0, 35)] ^= 1'b1;
      if ($urandom_range(0, 3) == 0) w[$urandom_range(0, 35)] ^= 1'b1;
      we = ($urandom_range(0, 15) == 0);
      wd = 16'($urandom);
      apply("R8 random", w, 2'($urandom), we, wd);
    end
    finish_run();
  end

endmodule